// File: doc/BRIEF.md
# Reset Supervisor with Watchdog

This block gathers the board-level reset requests into three nested active-low reset outputs: a power reset, a system reset and an I/O reset. The power reset follows the power-good flags of the supply rails. The system reset collects the power reset, a low-3.3 V flag, an active-low debug-port reset request, a front-panel button and a watchdog timeout. The I/O reset follows the system reset and a software control bit. Each wider reset always forces the narrower ones. After its last cause goes away, the system reset is held for a fixed 200 ms. A cause that returns during that hold starts the hold again.

The watchdog counts a fixed 1.6 s window. Any transition of the kick line restarts the window, whether rising or falling. If the window runs out, the watchdog pulses its active-low output for one cycle and forces a system reset. An enable input turns the watchdog off. A parameter gives the clock frequency, and both periods are derived from it. The asynchronous request inputs pass through two-flop synchronizers. A small register keeps the cause of the most recent system reset.

Top module: `rst_supervisor`

## Requirements
- R1: `por_n_o` is low while any bit of `rail_good_i` is 0. It goes high on the 3rd rising edge after all rails read good, and it falls again on the 3rd edge after any rail drops.
- R2: Whenever `por_n_o` is low, `sys_rst_n_o` is low in the same cycle.
- R3: `sys_rst_n_o` goes low by the 3rd rising edge after any of these inputs becomes active: `low33_i` high, `jtag_req_n_i` low, or `btn_i` high.
- R4: While `ext_temp_i` is 1, `btn_i` has no effect on `sys_rst_n_o` or on `last_cause_o`.
- R5: Once every cause is gone at the synchronizer outputs, `sys_rst_n_o` stays low for STRETCH = CLK_HZ/1000*SYS_HOLD_MS cycles. Seen from the input pins, it is still low STRETCH+1 edges after removal and high by STRETCH+3 edges. A cause that returns during the hold restarts the full count.
- R6: `io_rst_n_o` is registered. It goes low one edge after `sw_io_n_i` is 0 or `sys_rst_n_o` is low, and it goes high one edge after both are released.
- R7: With `wd_en_i` = 1 and no kick transition, `wd_out_n_o` pulses low for one cycle on the TIMEOUT-th edge after the count starts (TIMEOUT = CLK_HZ/1000*WD_PERIOD_MS). `sys_rst_n_o` falls on the next edge.
- R8: Both a rising and a falling transition on `kick_i` restart the watchdog count. Kicks spaced closer than TIMEOUT cycles keep `sys_rst_n_o` high.
- R9: While `wd_en_i` = 0, `wd_out_n_o` stays high. The count is also held at zero while the system reset is asserted.
- R10: `last_cause_o` latches the highest-priority cause at the start of each system reset, with priority in the order of these codes: 0 power, 1 low 3.3 V, 2 debug-port request, 3 button, 4 watchdog. It reads 0 after `arst_n` is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| arst_n | input | 1 | Asynchronous active-low reset of the block's own flops |
| rail_good_i | input | NUM_RAILS | One power-good flag per supply rail |
| low33_i | input | 1 | High when the 3.3 V rail is low |
| jtag_req_n_i | input | 1 | Active-low reset request from the debug port |
| btn_i | input | 1 | Reset button, high while pressed |
| ext_temp_i | input | 1 | Strap; 1 disables the button |
| sw_io_n_i | input | 1 | Software I/O reset bit, 0 asserts the I/O reset |
| kick_i | input | 1 | Watchdog kick, either edge restarts the count |
| wd_en_i | input | 1 | Watchdog enable |
| por_n_o | output | 1 | Power reset, active low |
| sys_rst_n_o | output | 1 | System reset, active low |
| io_rst_n_o | output | 1 | I/O reset, active low |
| wd_out_n_o | output | 1 | Watchdog timeout pulse, active low |
| last_cause_o | output | 3 | Cause code of the latest system reset |

## Verification
Each asynchronous input needs two synchronizer edges. The power reset and the system-reset assertion then need one more register, so both are due on the third edge after the input changes. The I/O reset follows the system reset one edge later. The bench drives every input one time unit after a rising edge and samples one time unit after the edge being counted. Each latency is checked on both sides: the output still holds its old value one edge early and shows the new value on the due edge. The 200 ms hold is checked as low at STRETCH+1 edges and high at STRETCH+3 edges after removal. The watchdog is checked as high at TIMEOUT-1 edges, pulsing at TIMEOUT and forcing the system reset at TIMEOUT+1, with both periods scaled down by setting CLK_HZ to 1000.

// File: rtl/rst_sup_pkg.sv
package rst_sup_pkg;

  typedef enum logic [2:0] {
    CAUSE_PWR   = 3'd0,
    CAUSE_LOW33 = 3'd1,
    CAUSE_JTAG  = 3'd2,
    CAUSE_BTN   = 3'd3,
    CAUSE_WDOG  = 3'd4
  } cause_e;

  // Highest-priority active source wins; power outranks everything.
  function automatic cause_e pick_cause(input logic pwr, input logic low,
                                        input logic dbg, input logic btn);
    if (pwr)      return CAUSE_PWR;
    else if (low) return CAUSE_LOW33;
    else if (dbg) return CAUSE_JTAG;
    else if (btn) return CAUSE_BTN;
    else          return CAUSE_WDOG;
  endfunction

endpackage

// File: rtl/rst_sync_bits.sv
module rst_sync_bits #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage1_q[b] <= 1'b0;
        stage2_q[b] <= 1'b0;
      end else begin
        stage1_q[b] <= d_i[b];
        stage2_q[b] <= stage1_q[b];
      end
    end
  end

  assign q_o = stage2_q;

endmodule

// File: rtl/rst_stretch.sv
module rst_stretch #(
  parameter int HOLD_CYC = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cause_i,
  output logic active_o
);

  localparam int CW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

  logic          active_q, active_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    if (cause_i) begin
      active_d = 1'b1;
      cnt_d    = '0;
    end else if (active_q) begin
      if (cnt_q == LAST) begin
        active_d = 1'b0;
        cnt_d    = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
    end
  end

  assign active_o = active_q;

endmodule

// File: rtl/rst_wdog.sv
module rst_wdog #(
  parameter int TIMEOUT_CYC = 1600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic hold_i,
  input  logic kick_s_i,
  output logic fire_o
);

  localparam int CW = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

  logic          kick_d_q;
  logic          kick_edge;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          fire_q, fire_d;

  assign kick_edge = kick_s_i ^ kick_d_q;

  always_comb begin
    cnt_d  = cnt_q;
    fire_d = 1'b0;
    if (!en_i || hold_i || kick_edge) begin
      cnt_d = '0;
    end else if (cnt_q == LAST) begin
      cnt_d  = '0;
      fire_d = 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kick_d_q <= 1'b0;
      cnt_q    <= '0;
      fire_q   <= 1'b0;
    end else begin
      kick_d_q <= kick_s_i;
      cnt_q    <= cnt_d;
      fire_q   <= fire_d;
    end
  end

  assign fire_o = fire_q;

endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
  import rst_sup_pkg::*;
#(
  parameter int CLK_HZ       = 100_000_000,
  parameter int NUM_RAILS    = 3,
  parameter int SYS_HOLD_MS  = 200,
  parameter int WD_PERIOD_MS = 1600
) (
  input  logic                 clk,
  input  logic                 arst_n,
  input  logic [NUM_RAILS-1:0] rail_good_i,
  input  logic                 low33_i,
  input  logic                 jtag_req_n_i,
  input  logic                 btn_i,
  input  logic                 ext_temp_i,
  input  logic                 sw_io_n_i,
  input  logic                 kick_i,
  input  logic                 wd_en_i,
  output logic                 por_n_o,
  output logic                 sys_rst_n_o,
  output logic                 io_rst_n_o,
  output logic                 wd_out_n_o,
  output logic [2:0]           last_cause_o
);

  localparam int CYC_PER_MS  = CLK_HZ / 1000;
  localparam int STRETCH_CYC = CYC_PER_MS * SYS_HOLD_MS;
  localparam int TIMEOUT_CYC = CYC_PER_MS * WD_PERIOD_MS;
  localparam int SW          = NUM_RAILS + 4;

  // Local reset: asserted asynchronously, released on a clock edge.
  logic rst_meta_q, rst_core_n;
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      rst_meta_q <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_core_n <= rst_meta_q;
    end
  end

  logic [SW-1:0]        sync_q;
  logic [NUM_RAILS-1:0] rail_s;
  logic                 low_s, dbg_n_s, btn_s, kick_s;

  rst_sync_bits #(.W(SW)) u_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d_i   ({kick_i, btn_i, jtag_req_n_i, low33_i, rail_good_i}),
    .q_o   (sync_q)
  );

  assign rail_s  = sync_q[NUM_RAILS-1:0];
  assign low_s   = sync_q[NUM_RAILS];
  assign dbg_n_s = sync_q[NUM_RAILS+1];
  assign btn_s   = sync_q[NUM_RAILS+2];
  assign kick_s  = sync_q[NUM_RAILS+3];

  logic c_pwr, c_low, c_dbg, c_btn, c_wd, any_cause;
  logic sys_active;

  assign c_pwr     = ~&rail_s;
  assign c_low     = low_s;
  assign c_dbg     = ~dbg_n_s;
  assign c_btn     = btn_s & ~ext_temp_i;
  assign any_cause = c_pwr | c_low | c_dbg | c_btn | c_wd;

  rst_stretch #(.HOLD_CYC(STRETCH_CYC)) u_stretch (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .cause_i  (any_cause),
    .active_o (sys_active)
  );

  rst_wdog #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_wdog (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .en_i     (wd_en_i),
    .hold_i   (sys_active),
    .kick_s_i (kick_s),
    .fire_o   (c_wd)
  );

  logic   por_n_q, por_n_d;
  logic   io_n_q, io_n_d;
  cause_e cause_q, cause_d;

  always_comb begin
    por_n_d = &rail_s;
    io_n_d  = sw_io_n_i & ~sys_active;
    cause_d = cause_q;
    if (any_cause && !sys_active) begin
      cause_d = pick_cause(c_pwr, c_low, c_dbg, c_btn);
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      por_n_q <= 1'b0;
      io_n_q  <= 1'b0;
      cause_q <= CAUSE_PWR;
    end else begin
      por_n_q <= por_n_d;
      io_n_q  <= io_n_d;
      cause_q <= cause_d;
    end
  end

  assign por_n_o      = por_n_q;
  assign sys_rst_n_o  = ~sys_active;
  assign io_rst_n_o   = io_n_q;
  assign wd_out_n_o   = ~c_wd;
  assign last_cause_o = cause_q;

endmodule

// File: rtl/rst_supervisor_chk.sv
module rst_supervisor_chk (
  input logic clk,
  input logic arst_n,
  input logic wd_en_i,
  input logic por_n_o,
  input logic sys_rst_n_o,
  input logic io_rst_n_o,
  input logic wd_out_n_o
);

  AST_POR_FORCES_SYS: assert property (@(posedge clk) disable iff (!arst_n)
    !por_n_o |-> !sys_rst_n_o); // R2

  AST_SYS_FORCES_IO: assert property (@(posedge clk) disable iff (!arst_n)
    !sys_rst_n_o |=> !io_rst_n_o); // R6

  AST_WD_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!arst_n)
    !wd_out_n_o |=> wd_out_n_o); // R7

  AST_WD_FORCES_SYS: assert property (@(posedge clk) disable iff (!arst_n)
    !wd_out_n_o |=> !sys_rst_n_o); // R7

  AST_RELEASE_NEEDS_POWER: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(sys_rst_n_o) |-> por_n_o); // R5

  AST_WD_QUIET_OFF: assert property (@(posedge clk) disable iff (!arst_n)
    !wd_en_i |=> wd_out_n_o); // R9

endmodule

bind rst_supervisor rst_supervisor_chk u_chk (.*);

// File: tb/tb_rst_supervisor.sv
module tb_rst_supervisor;

  localparam int CLK_HZ  = 1000;
  localparam int NR      = 3;
  localparam int STRETCH = CLK_HZ / 1000 * 200;
  localparam int TMO     = CLK_HZ / 1000 * 1600;

  logic          clk = 1'b0;
  logic          arst_n;
  logic [NR-1:0] rail_good;
  logic          low33, dbg_n, btn, strap, sw_io_n, kick, wd_en;
  logic          por_n, sys_n, io_n, wd_n;
  logic [2:0]    cause;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  rst_supervisor #(.CLK_HZ(CLK_HZ), .NUM_RAILS(NR)) dut (
    .clk(clk), .arst_n(arst_n), .rail_good_i(rail_good), .low33_i(low33),
    .jtag_req_n_i(dbg_n), .btn_i(btn), .ext_temp_i(strap), .sw_io_n_i(sw_io_n),
    .kick_i(kick), .wd_en_i(wd_en), .por_n_o(por_n), .sys_rst_n_o(sys_n),
    .io_rst_n_o(io_n), .wd_out_n_o(wd_n), .last_cause_o(cause)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_release(input string req);
    int n = 0;
    while (!sys_n && n < STRETCH + 20) begin
      step(1);
      n++;
    end
    check(req, "system reset released", sys_n, 1);
  endtask

  task automatic t_reset;
    arst_n = 1'b0; rail_good = '0; low33 = 1'b0; dbg_n = 1'b1; btn = 1'b0;
    strap = 1'b0; sw_io_n = 1'b1; kick = 1'b0; wd_en = 1'b0;
    step(4);
    arst_n = 1'b1;
    step(3);
    check("R1", "por after reset", por_n, 0);
    check("R2", "sys after reset", sys_n, 0);
    check("R6", "io after reset", io_n, 0);
    check("R9", "wd_out after reset", wd_n, 1);
    check("R10", "cause after reset", cause, 0);
  endtask

  task automatic t_power_up;
    rail_good = 3'b011;
    step(6);
    check("R1", "por with one rail bad", por_n, 0);
    rail_good = '1;
    step(2);
    check("R1", "por one edge early", por_n, 0);
    step(1);
    check("R1", "por on third edge", por_n, 1);
    check("R2", "sys still held", sys_n, 0);
    step(STRETCH + 1 - 3);
    check("R5", "sys held at STRETCH+1", sys_n, 0);
    step(2);
    check("R5", "sys released by STRETCH+3", sys_n, 1);
    step(1);
    check("R6", "io follows sys release", io_n, 1);
  endtask

  task automatic t_dbg_restart;
    dbg_n = 1'b0;
    step(2);
    check("R3", "debug request one edge early", sys_n, 1);
    step(1);
    check("R3", "debug request asserts sys", sys_n, 0);
    check("R10", "cause debug", cause, 2);
    step(1);
    check("R6", "io follows sys", io_n, 0);
    dbg_n = 1'b1;
    step(100);
    dbg_n = 1'b0;
    step(5);
    dbg_n = 1'b1;
    step(STRETCH + 1);
    check("R5", "restarted hold still low", sys_n, 0);
    step(2);
    check("R5", "restarted hold released", sys_n, 1);
  endtask

  task automatic t_low33;
    low33 = 1'b1;
    step(3);
    check("R3", "low 3.3V asserts sys", sys_n, 0);
    check("R10", "cause low33", cause, 1);
    low33 = 1'b0;
    wait_release("R3");
  endtask

  task automatic t_button;
    btn = 1'b1;
    step(3);
    check("R3", "button asserts sys", sys_n, 0);
    check("R10", "cause button", cause, 3);
    btn = 1'b0;
    wait_release("R3");
  endtask

  task automatic t_button_strap;
    strap = 1'b1;
    btn = 1'b1;
    for (int i = 0; i < 4; i++) begin
      step(5);
      check("R4", "button ignored with strap", sys_n, 1);
    end
    check("R4", "cause unchanged", cause, 3);
    btn = 1'b0;
    step(3);
    strap = 1'b0;
  endtask

  task automatic t_sw_io;
    sw_io_n = 1'b0;
    step(1);
    check("R6", "sw bit asserts io", io_n, 0);
    check("R6", "sys unaffected by sw bit", sys_n, 1);
    sw_io_n = 1'b1;
    step(1);
    check("R6", "sw bit release", io_n, 1);
  endtask

  task automatic t_rail_drop;
    rail_good = 3'b101;
    step(3);
    check("R1", "por reasserts on rail drop", por_n, 0);
    check("R2", "sys with por", sys_n, 0);
    check("R10", "cause power", cause, 0);
    step(1);
    check("R2", "io with por", io_n, 0);
    rail_good = '1;
    step(3);
    check("R1", "por high after restore", por_n, 1);
    wait_release("R1");
  endtask

  task automatic t_wd_fire;
    wd_en = 1'b1;
    step(TMO - 1);
    check("R7", "no pulse at TIMEOUT-1", wd_n, 1);
    check("R7", "sys high at TIMEOUT-1", sys_n, 1);
    step(1);
    check("R7", "pulse at TIMEOUT", wd_n, 0);
    step(1);
    check("R7", "sys asserted after pulse", sys_n, 0);
    check("R7", "pulse is one cycle", wd_n, 1);
    check("R10", "cause watchdog", cause, 4);
    wd_en = 1'b0;
    wait_release("R7");
  endtask

  task automatic t_wd_kick;
    wd_en = 1'b1;
    for (int i = 0; i < 6; i++) begin
      step(TMO / 2);
      kick = ~kick;
      check("R8", "kicked watchdog keeps sys", sys_n, 1);
      check("R8", "kicked watchdog no pulse", wd_n, 1);
    end
    step(TMO + 6);
    check("R8", "missed kicks cause reset", sys_n, 0);
    wd_en = 1'b0;
    wait_release("R8");
  endtask

  task automatic t_wd_off;
    wd_en = 1'b0;
    for (int i = 0; i < 4; i++) begin
      step(TMO / 2 + 7);
      check("R9", "disabled watchdog sys", sys_n, 1);
      check("R9", "disabled watchdog pulse", wd_n, 1);
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_power_up();
    t_dbg_restart();
    t_low33();
    t_button();
    t_button_strap();
    t_sw_io();
    t_rail_drop();
    t_wd_fire();
    t_wd_kick();
    t_wd_off();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule